// File: doc/BRIEF.md
# Debug-mode reset suppression controller

This block sits inside a supervisory controller and decides what happens when watchdog-class faults arrive while a software-development debug mode is active. In debug mode, watchdog overflow, window miss, interrupt timeout and start-up expiry raise a one-cycle interrupt instead of a system reset. Fail-safe entry is blocked except for a long supply undervoltage. The reset-source code is logged for every event, whether the reset is suppressed or not.

Debug mode is entered in one of two ways. A test strap can be high on the first clock after power-on reset. Software can also set the enable bit in a single special-mode register write, made while the controller is in Start-up. Every mode-register write must carry the debug bit, or debug mode ends. Once debug mode has ended, only a new power-on reset allows it again. All outputs are registered and follow their cause by one clock.

Top module: `dbg_rst_guard`

## Requirements
- R1: Outside debug mode, any of `ev_wd_ovf`, `ev_win_miss`, `ev_int_tmo`, `ev_start_exp` in a cycle makes `rst_req` high in the next cycle, and `irq` stays low.
- R2: In debug mode with `op_mode` other than Standby (3) or Sleep (4), those four events leave `rst_req` low and instead make `irq` high for the next cycle only.
- R3: In debug mode with `op_mode` equal to Standby (3) or Sleep (4), those events assert `rst_req` as in R1 and `irq` stays low.
- R4: `rst_src` is 0 after power-on reset. On any event it takes the code of the highest-priority event of that cycle, whether the event is masked or not: undervoltage 5, start-up expiry 4, interrupt timeout 3, window miss 2, watchdog overflow 1. Otherwise it holds its value.
- R5: `fs_req` follows `ev_uv_long` or `ev_fs` by one cycle outside debug mode. In debug mode, only `ev_uv_long` raises it.
- R6: `restart_req` follows `go_restart` by one cycle while `op_mode` is Start-up (0), whatever the debug state.
- R7: On the first clock after `por_n` rises, `dbg_active` takes the value of `strap_test`. Writes made in that cycle are ignored.
- R8: A `spec_wr` with `spec_dbg_en` high enters debug mode only if `op_mode` is Start-up (0) and no earlier `spec_wr` has been made since power-on. Any `spec_wr` uses up that single chance.
- R9: A `mode_wr` with `mode_dbg` low clears `dbg_active` on the next cycle, however debug mode was entered. A `mode_wr` with `mode_dbg` high keeps the current state and never enters debug mode. A mode write in the same cycle as a special-mode write takes precedence over it.
- R10: After debug mode has been exited, no special-mode write re-enters it until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| strap_test | input | 1 | Test strap level, sampled after power-on |
| spec_wr | input | 1 | Special-mode register write strobe |
| spec_dbg_en | input | 1 | Debug enable bit of the special-mode write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_dbg | input | 1 | Debug keep bit of the mode write |
| op_mode | input | 3 | Operating mode: 0 Start-up, 1 Restart, 2 Normal, 3 Standby, 4 Sleep, 5 Fail-safe |
| ev_wd_ovf | input | 1 | Watchdog overflow pulse |
| ev_win_miss | input | 1 | Watchdog window miss pulse |
| ev_int_tmo | input | 1 | Interrupt timeout pulse |
| ev_start_exp | input | 1 | Start-up time elapsed pulse |
| ev_uv_long | input | 1 | Qualified long undervoltage pulse |
| ev_fs | input | 1 | Other fail-safe trigger |
| go_restart | input | 1 | Start-up to Restart request |
| rst_req | output | 1 | System reset request |
| fs_req | output | 1 | Fail-safe entry request |
| restart_req | output | 1 | Restart transition request |
| irq | output | 1 | Interrupt pulse for a suppressed reset |
| rst_src | output | 3 | Latched reset-source code |
| dbg_active | output | 1 | Debug mode active |

## Verification
The assertions assume that `op_mode` is one of the six defined codes and that event inputs are synchronous pulses sampled on the rising clock edge. The properties also assume that `por_n` is the only way to clear the block's history. The stimulus changes every input only on the falling edge. It draws `op_mode` only from 0 to 5 and applies power-on reset by holding `por_n` low for several whole cycles, with a random strap level. Write strobes are kept rare, so that debug sessions last long enough to meet many masked events in every operating mode.

// File: rtl/dbg_rst_guard.sv
module dbg_rst_guard #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          strap_test,
  input  logic          spec_wr,
  input  logic          spec_dbg_en,
  input  logic          mode_wr,
  input  logic          mode_dbg,
  input  logic [MW-1:0] op_mode,
  input  logic          ev_wd_ovf,
  input  logic          ev_win_miss,
  input  logic          ev_int_tmo,
  input  logic          ev_start_exp,
  input  logic          ev_uv_long,
  input  logic          ev_fs,
  input  logic          go_restart,
  output logic          rst_req,
  output logic          fs_req,
  output logic          restart_req,
  output logic          irq,
  output logic [2:0]    rst_src,
  output logic          dbg_active
);
  localparam logic [MW-1:0] M_START = MW'(0);
  localparam logic [MW-1:0] M_STBY  = MW'(3);
  localparam logic [MW-1:0] M_SLEEP = MW'(4);

  logic boot_q, used_q, exited_q;

  wire wd_any  = ev_wd_ovf | ev_win_miss | ev_int_tmo | ev_start_exp;
  wire low_pwr = (op_mode == M_STBY) || (op_mode == M_SLEEP);
  wire masked  = dbg_active & ~low_pwr;
  wire in_start = (op_mode == M_START);
  wire spec_ok = spec_wr & spec_dbg_en & ~used_q & ~exited_q & in_start;
  wire drop    = mode_wr & ~mode_dbg;

  logic [2:0] src_nxt;
  always_comb begin
    src_nxt = rst_src;
    if      (ev_uv_long)   src_nxt = 3'd5;
    else if (ev_start_exp) src_nxt = 3'd4;
    else if (ev_int_tmo)   src_nxt = 3'd3;
    else if (ev_win_miss)  src_nxt = 3'd2;
    else if (ev_wd_ovf)    src_nxt = 3'd1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_req     <= 1'b0;
      fs_req      <= 1'b0;
      restart_req <= 1'b0;
      irq         <= 1'b0;
      rst_src     <= 3'd0;
    end else begin
      rst_req     <= wd_any & ~masked;
      irq         <= wd_any & masked;
      fs_req      <= ev_uv_long | (ev_fs & ~dbg_active);
      restart_req <= go_restart & in_start;
      rst_src     <= src_nxt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      boot_q     <= 1'b1;
      dbg_active <= 1'b0;
      used_q     <= 1'b0;
      exited_q   <= 1'b0;
    end else if (boot_q) begin
      boot_q     <= 1'b0;
      dbg_active <= strap_test;
    end else begin
      if (spec_wr) used_q <= 1'b1;
      if (drop) begin
        if (dbg_active) exited_q <= 1'b1;
        dbg_active <= 1'b0;
      end else if (spec_ok) begin
        dbg_active <= 1'b1;
      end
    end
  end
endmodule

module dbg_rst_guard_chk #(
  parameter int MW = 3
) (
  input logic          clk,
  input logic          por_n,
  input logic          mode_wr,
  input logic          mode_dbg,
  input logic [MW-1:0] op_mode,
  input logic          ev_wd_ovf,
  input logic          ev_win_miss,
  input logic          ev_int_tmo,
  input logic          ev_start_exp,
  input logic          ev_uv_long,
  input logic          rst_req,
  input logic          fs_req,
  input logic          irq,
  input logic [2:0]    rst_src,
  input logic          dbg_active,
  input logic          exited_q
);
  wire wd = ev_wd_ovf | ev_win_miss | ev_int_tmo | ev_start_exp;
  wire lp = (op_mode == MW'(3)) || (op_mode == MW'(4));

  p_irq_excl_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(irq && rst_req));
  p_masked_r2: assert property (@(posedge clk) disable iff (!por_n)
    dbg_active && wd && !lp |=> !rst_req && irq);
  p_lowpwr_r3: assert property (@(posedge clk) disable iff (!por_n)
    wd && lp |=> rst_req);
  p_plain_r1: assert property (@(posedge clk) disable iff (!por_n)
    !dbg_active && wd |=> rst_req);
  p_uv_src_r4: assert property (@(posedge clk) disable iff (!por_n)
    ev_uv_long |=> rst_src == 3'd5);
  p_uv_fs_r5: assert property (@(posedge clk) disable iff (!por_n)
    ev_uv_long |=> fs_req);
  p_exit_r9: assert property (@(posedge clk) disable iff (!por_n)
    dbg_active && mode_wr && !mode_dbg |=> !dbg_active);
  p_noreentry_r10: assert property (@(posedge clk) disable iff (!por_n)
    exited_q |=> !dbg_active);
endmodule

bind dbg_rst_guard dbg_rst_guard_chk #(.MW(MW)) u_chk (
  .clk(clk), .por_n(por_n), .mode_wr(mode_wr), .mode_dbg(mode_dbg),
  .op_mode(op_mode), .ev_wd_ovf(ev_wd_ovf), .ev_win_miss(ev_win_miss),
  .ev_int_tmo(ev_int_tmo), .ev_start_exp(ev_start_exp),
  .ev_uv_long(ev_uv_long), .rst_req(rst_req), .fs_req(fs_req), .irq(irq),
  .rst_src(rst_src), .dbg_active(dbg_active), .exited_q(exited_q)
);

// File: tb/dbg_rst_guard_tb.sv
module dbg_rst_guard_tb;
  localparam int TCK = 10;

  logic clk = 0, por_n = 0, strap_test = 0;
  logic spec_wr = 0, spec_dbg_en = 0, mode_wr = 0, mode_dbg = 0;
  logic [2:0] op_mode = 0;
  logic ev_wd_ovf = 0, ev_win_miss = 0, ev_int_tmo = 0, ev_start_exp = 0;
  logic ev_uv_long = 0, ev_fs = 0, go_restart = 0;
  logic rst_req, fs_req, restart_req, irq, dbg_active;
  logic [2:0] rst_src;

  int checks = 0, errors = 0;
  bit m_boot, m_used, m_exit, m_dbg, m_rst, m_fs, m_rsr, m_irq;
  logic [2:0] m_src;

  always #(TCK/2) clk = ~clk;

  dbg_rst_guard u_dut (.*);

  initial begin
    #(TCK*200000);
    errors++;
    $display("FAIL watchdog: run hung, got no end, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] src_of(logic [2:0] old);
    if (ev_uv_long) return 3'd5;
    if (ev_start_exp) return 3'd4;
    if (ev_int_tmo) return 3'd3;
    if (ev_win_miss) return 3'd2;
    if (ev_wd_ovf) return 3'd1;
    return old;
  endfunction

  task automatic model_reset();
    m_boot = 1; m_used = 0; m_exit = 0; m_dbg = 0;
    m_rst = 0; m_fs = 0; m_rsr = 0; m_irq = 0; m_src = 0;
  endtask

  task automatic model_step();
    bit wd, mask;
    wd = ev_wd_ovf | ev_win_miss | ev_int_tmo | ev_start_exp;
    mask = m_dbg && !(op_mode == 3 || op_mode == 4);
    m_rst = wd && !mask;
    m_irq = wd && mask;
    m_fs = ev_uv_long || (ev_fs && !m_dbg);
    m_rsr = go_restart && op_mode == 0;
    m_src = src_of(m_src);
    if (m_boot) begin
      m_dbg = strap_test; m_boot = 0;
    end else begin
      bit ok;
      ok = spec_wr && spec_dbg_en && !m_used && !m_exit && op_mode == 0;
      if (spec_wr) m_used = 1;
      if (mode_wr && !mode_dbg) begin
        if (m_dbg) m_exit = 1;
        m_dbg = 0;
      end else if (ok) m_dbg = 1;
    end
  endtask

  task automatic compare();
    chk("R1/R3 rst_req", rst_req, m_rst);
    chk("R2 irq", irq, m_irq);
    chk("R4 rst_src", rst_src, m_src);
    chk("R5 fs_req", fs_req, m_fs);
    chk("R6 restart_req", restart_req, m_rsr);
    chk("R7-R10 dbg_active", dbg_active, m_dbg);
  endtask

  task automatic clear_in();
    spec_wr = 0; mode_wr = 0; ev_wd_ovf = 0; ev_win_miss = 0; ev_int_tmo = 0;
    ev_start_exp = 0; ev_uv_long = 0; ev_fs = 0; go_restart = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    clear_in();
  endtask

  task automatic power_on(input bit strap);
    @(negedge clk);
    por_n = 0; strap_test = strap; clear_in();
    model_reset();
    repeat (2) @(negedge clk);
    compare();
    por_n = 1;
  endtask

  initial begin
    int seed;
    seed = 0;
    void'($urandom(32'h5eed));
    // R7: strap entry, then R2 masking in Normal
    power_on(1);
    cyc();
    chk("R7 strap entry", dbg_active, 1);
    op_mode = 2; ev_wd_ovf = 1; cyc();
    chk("R2 masked overflow no reset", rst_req, 0);
    chk("R4 logged code 1", rst_src, 1);
    // R3: sleep still resets
    op_mode = 4; ev_win_miss = 1; cyc();
    chk("R3 sleep reset", rst_req, 1);
    // R5: fs blocked, uv passes
    op_mode = 2; ev_fs = 1; cyc();
    chk("R5 fs blocked", fs_req, 0);
    ev_uv_long = 1; ev_start_exp = 1; cyc();
    chk("R5 uv fs", fs_req, 1);
    chk("R4 uv priority", rst_src, 5);
    // R6 restart allowed in debug
    op_mode = 0; go_restart = 1; cyc();
    chk("R6 restart in debug", restart_req, 1);
    // R9 keep then exit
    mode_wr = 1; mode_dbg = 1; cyc();
    chk("R9 keep", dbg_active, 1);
    mode_wr = 1; mode_dbg = 0; cyc();
    chk("R9 exit", dbg_active, 0);
    // R10 no re-entry through special write
    spec_wr = 1; spec_dbg_en = 1; cyc();
    chk("R10 no reentry", dbg_active, 0);
    ev_int_tmo = 1; cyc();
    chk("R1 reset after exit", rst_req, 1);
    // R8: software entry and single use
    power_on(0);
    op_mode = 0; cyc();
    chk("R7 no strap", dbg_active, 0);
    spec_wr = 1; spec_dbg_en = 0; cyc();
    spec_wr = 1; spec_dbg_en = 1; cyc();
    chk("R8 second special write ignored", dbg_active, 0);
    power_on(0);
    op_mode = 2; cyc();
    spec_wr = 1; spec_dbg_en = 1; cyc();
    chk("R8 refused outside start-up", dbg_active, 0);
    power_on(0);
    op_mode = 0; cyc();
    spec_wr = 1; spec_dbg_en = 1; cyc();
    chk("R8 software entry", dbg_active, 1);
    ev_int_tmo = 1; op_mode = 1; cyc();
    chk("R2 irq pulse", irq, 1);
    cyc();
    chk("R2 irq one cycle", irq, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 399) == 0) begin
        power_on($urandom_range(0, 1));
      end
      if ($urandom_range(0, 15) == 0) op_mode = 3'($urandom_range(0, 5));
      ev_wd_ovf = ($urandom_range(0, 9) == 0);
      ev_win_miss = ($urandom_range(0, 9) == 0);
      ev_int_tmo = ($urandom_range(0, 9) == 0);
      ev_start_exp = ($urandom_range(0, 9) == 0);
      ev_uv_long = ($urandom_range(0, 19) == 0);
      ev_fs = ($urandom_range(0, 9) == 0);
      go_restart = ($urandom_range(0, 7) == 0);
      spec_wr = ($urandom_range(0, 29) == 0);
      spec_dbg_en = ($urandom_range(0, 3) != 0);
      mode_wr = ($urandom_range(0, 19) == 0);
      mode_dbg = ($urandom_range(0, 9) != 0);
      cyc();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule